// File: doc/BRIEF.md
# 1-Wire Time Slot Generator

This block sequences the bus-master side of a 1-Wire link. A single strobe starts one operation, which is one of three. A write-zero slot pulls the line low for most of the slot. A write-one/read slot pulls the line low only briefly and then samples the line. A reset cycle pulls the line low for a long interval, then releases it and checks the line twice: once for a short circuit and once for a presence pulse. The line is driven through an open-drain pulldown request. Its level comes back as a digital bus-high input from a threshold comparator.

All timing is counted in ticks of a 0.25 µs enable pulse, so the system clock frequency does not matter. The host selects standard or overdrive speed and supplies 4-bit codes for the programmable durations. Reset low time, presence sample time and write-zero low time each have separate codes for the two speeds. The recovery time has one code that serves both speeds. The other timing points are fixed for each speed. Byte handling, the host bus and the analog pullups are outside this block.

Top module: `owire_slot_gen`

## Requirements
- R1: With opReset=0 and dataBit=0, pullLow stays high for tW0L ticks and busy stays high for tW0L+tREC0 ticks. tW0L is 208+4·code ticks at standard speed and 20+code ticks at overdrive. tREC0 is 11+6·recCode ticks at both speeds. Only cycles with tickEn=1 advance the timing.
- R2: With opReset=0 and dataBit=1, pullLow stays high for 32 ticks (standard) or 3 ticks (overdrive). The slot still lasts tW0L+tREC0 ticks.
- R3: Every bit slot samples busHigh on its 48th tick (standard) or 7th tick (overdrive) after start, and rdBit then shows that sampled level.
- R4: With opReset=1, pullLow stays high for tRSTL ticks and busy stays high for 2·tRSTL ticks. tRSTL is 1760+80·code ticks at standard speed and 176+8·code ticks at overdrive.
- R5: A reset cycle samples busHigh on tick tRSTL+32 (standard) or tRSTL+3 (overdrive). shortDet is 1 if that sample was low.
- R6: A reset cycle samples busHigh on tick tRSTL+tMSP, where tMSP is 232+4·code (standard) or 22+code (overdrive). presence is 1 if that sample was low.
- R7: overdrive=1 selects the overdrive timing set for every operation, including the reset cycle. The speed, the operation and all codes are captured at start, so later changes do not affect the running operation.
- R8: A start that arrives while busy is high is ignored. The running operation keeps its timing and its kind.
- R9: An accepted start clears rdBit, presence and shortDet. busy falls at the clock edge of the final tick. The results then hold until the next accepted start. pullLow is never high while busy is low.
- R10: After reset, busy, pullLow, rdBit, presence and shortDet are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | 0.25 µs timing enable, one clock wide |
| start | input | 1 | Start strobe for one operation |
| opReset | input | 1 | 1 = reset/presence cycle, 0 = bit slot |
| dataBit | input | 1 | Bit slot kind: 0 = write-zero, 1 = write-one/read |
| overdrive | input | 1 | 1 = overdrive timing, 0 = standard timing |
| rstLowStd | input | 4 | Reset low time code, standard speed |
| rstLowOd | input | 4 | Reset low time code, overdrive |
| presStd | input | 4 | Presence sample time code, standard speed |
| presOd | input | 4 | Presence sample time code, overdrive |
| w0LowStd | input | 4 | Write-zero low time code, standard speed |
| w0LowOd | input | 4 | Write-zero low time code, overdrive |
| recCode | input | 4 | Recovery time code, both speeds |
| busHigh | input | 1 | Comparator output, 1 = line above the high threshold |
| pullLow | output | 1 | Request to pull the line low |
| busy | output | 1 | Operation in progress |
| rdBit | output | 1 | Level sampled in the last bit slot |
| presence | output | 1 | Presence pulse seen in the last reset cycle |
| shortDet | output | 1 | Line low at the short-check instant of the last reset cycle |

## Verification
The operations are drawn at random across both speeds, all code values and both data bits. The tick enable arrives with random gaps, which shows whether timing is counted in ticks rather than clock cycles. The bench drives busHigh to the wanted level only on the exact sample tick and to the opposite level on the ticks around it. A sample taken one tick early or late therefore reads the wrong value. The codes are rewritten and a conflicting start is pulsed in the middle of some operations, which shows whether the timing was captured at start and whether starts while busy are ignored. Directed cases cover the extreme codes of the long standard-speed reset cycle and the holding of results over idle ticks.

// File: rtl/ow_slot_pkg.sv
`timescale 1ns/1ps
package ow_slot_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // accept a new operation
    logic step;      // one tick elapsed
    logic relLow;    // end of the low phase
    logic smpBit;    // read sample of a bit slot
    logic smpShort;  // short check of a reset cycle
    logic smpPres;   // presence check of a reset cycle
  } owStb_t;

  // fixed points, in 0.25 us ticks
  localparam int STD_W1L = 32;
  localparam int OD_W1L  = 3;
  localparam int STD_MSR = 48;
  localparam int OD_MSR  = 7;
  localparam int STD_SI  = 32;
  localparam int OD_SI   = 3;

  // programmable points: base + step * code, in ticks
  localparam int STD_RSTL_BASE = 1760;
  localparam int STD_RSTL_STEP = 80;
  localparam int OD_RSTL_BASE  = 176;
  localparam int OD_RSTL_STEP  = 8;
  localparam int STD_MSP_BASE  = 232;
  localparam int STD_MSP_STEP  = 4;
  localparam int OD_MSP_BASE   = 22;
  localparam int OD_MSP_STEP   = 1;
  localparam int STD_W0L_BASE  = 208;
  localparam int STD_W0L_STEP  = 4;
  localparam int OD_W0L_BASE   = 20;
  localparam int OD_W0L_STEP   = 1;
  localparam int REC_BASE      = 11;
  localparam int REC_STEP      = 6;

endpackage

// File: rtl/ow_slot_timing.sv
`timescale 1ns/1ps
module ow_slot_timing
  import ow_slot_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 13
) (
  input  logic              overdrive,
  input  logic              opReset,
  input  logic              dataBit,
  input  logic [CODE_W-1:0] rstLowStd,
  input  logic [CODE_W-1:0] rstLowOd,
  input  logic [CODE_W-1:0] presStd,
  input  logic [CODE_W-1:0] presOd,
  input  logic [CODE_W-1:0] w0LowStd,
  input  logic [CODE_W-1:0] w0LowOd,
  input  logic [CODE_W-1:0] recCode,
  output logic [CNT_W-1:0]  lowLen,
  output logic [CNT_W-1:0]  endLen,
  output logic [CNT_W-1:0]  smpA,
  output logic [CNT_W-1:0]  smpB
);

  function automatic logic [CNT_W-1:0] scale(input int base, input int stepSz,
                                             input logic [CODE_W-1:0] code);
    return CNT_W'(base + stepSz * int'(code));
  endfunction

  logic [CNT_W-1:0] rstl, msp, w0l, rec, w1l, msr, si;

  always_comb begin
    rstl = overdrive ? scale(OD_RSTL_BASE, OD_RSTL_STEP, rstLowOd)
                     : scale(STD_RSTL_BASE, STD_RSTL_STEP, rstLowStd);
    msp  = overdrive ? scale(OD_MSP_BASE, OD_MSP_STEP, presOd)
                     : scale(STD_MSP_BASE, STD_MSP_STEP, presStd);
    w0l  = overdrive ? scale(OD_W0L_BASE, OD_W0L_STEP, w0LowOd)
                     : scale(STD_W0L_BASE, STD_W0L_STEP, w0LowStd);
    rec  = scale(REC_BASE, REC_STEP, recCode);
    w1l  = overdrive ? CNT_W'(OD_W1L) : CNT_W'(STD_W1L);
    msr  = overdrive ? CNT_W'(OD_MSR) : CNT_W'(STD_MSR);
    si   = overdrive ? CNT_W'(OD_SI)  : CNT_W'(STD_SI);

    if (opReset) begin
      lowLen = rstl;
      endLen = rstl + rstl;
      smpA   = rstl + si;
      smpB   = rstl + msp;
    end else begin
      lowLen = dataBit ? w1l : w0l;
      endLen = w0l + rec;
      smpA   = msr;
      smpB   = '0;   // never reached: the count starts at 1
    end
  end

endmodule

// File: rtl/ow_slot_dp.sv
`timescale 1ns/1ps
module ow_slot_dp
  import ow_slot_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  owStb_t           stb,
  input  logic             busHigh,
  input  logic [CNT_W-1:0] lowLenIn,
  input  logic [CNT_W-1:0] endLenIn,
  input  logic [CNT_W-1:0] smpAIn,
  input  logic [CNT_W-1:0] smpBIn,
  output logic             hitLow,
  output logic             hitA,
  output logic             hitB,
  output logic             hitEnd,
  output logic             pullLow,
  output logic             rdBit,
  output logic             presence,
  output logic             shortDet
);

  logic [CNT_W-1:0] cnt, nextCnt;
  logic [CNT_W-1:0] lowLen, endLen, smpA, smpB;

  assign nextCnt = cnt + 1'b1;
  assign hitLow  = (nextCnt == lowLen);
  assign hitA    = (nextCnt == smpA);
  assign hitB    = (nextCnt == smpB);
  assign hitEnd  = (nextCnt == endLen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      lowLen   <= '0;
      endLen   <= '0;
      smpA     <= '0;
      smpB     <= '0;
      pullLow  <= 1'b0;
      rdBit    <= 1'b0;
      presence <= 1'b0;
      shortDet <= 1'b0;
    end else if (stb.load) begin
      cnt      <= '0;
      lowLen   <= lowLenIn;
      endLen   <= endLenIn;
      smpA     <= smpAIn;
      smpB     <= smpBIn;
      pullLow  <= 1'b1;
      rdBit    <= 1'b0;
      presence <= 1'b0;
      shortDet <= 1'b0;
    end else begin
      if (stb.step)     cnt      <= nextCnt;
      if (stb.relLow)   pullLow  <= 1'b0;
      if (stb.smpBit)   rdBit    <= busHigh;
      if (stb.smpShort) shortDet <= !busHigh;
      if (stb.smpPres)  presence <= !busHigh;
    end
  end

  AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.smpBit, stb.smpShort, stb.smpPres}));  // R5
  AST_RELEASE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    stb.relLow |-> pullLow);  // R1
  AST_STEP_BELOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    stb.step |-> (cnt < endLen));  // R4

endmodule

// File: rtl/ow_slot_ctrl.sv
`timescale 1ns/1ps
module ow_slot_ctrl
  import ow_slot_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   tickEn,
  input  logic   opReset,
  input  logic   hitLow,
  input  logic   hitA,
  input  logic   hitB,
  input  logic   hitEnd,
  output owStb_t stb,
  output logic   busy
);

  logic opRst;
  logic finish;

  always_comb begin
    stb      = '0;
    finish   = 1'b0;
    stb.load = start && !busy;
    if (busy && tickEn) begin
      stb.step     = 1'b1;
      stb.relLow   = hitLow;
      stb.smpBit   = hitA && !opRst;
      stb.smpShort = hitA && opRst;
      stb.smpPres  = hitB && opRst;
      finish       = hitEnd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      opRst <= 1'b0;
    end else if (stb.load) begin
      busy  <= 1'b1;
      opRst <= opReset;
    end else if (finish) begin
      busy  <= 1'b0;
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> (busy && $stable(opRst)));  // R8

endmodule

// File: rtl/owire_slot_gen.sv
`timescale 1ns/1ps
module owire_slot_gen
  import ow_slot_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic              start,
  input  logic              opReset,
  input  logic              dataBit,
  input  logic              overdrive,
  input  logic [CODE_W-1:0] rstLowStd,
  input  logic [CODE_W-1:0] rstLowOd,
  input  logic [CODE_W-1:0] presStd,
  input  logic [CODE_W-1:0] presOd,
  input  logic [CODE_W-1:0] w0LowStd,
  input  logic [CODE_W-1:0] w0LowOd,
  input  logic [CODE_W-1:0] recCode,
  input  logic              busHigh,
  output logic              pullLow,
  output logic              busy,
  output logic              rdBit,
  output logic              presence,
  output logic              shortDet
);

  owStb_t           stb;
  logic [CNT_W-1:0] lowLen, endLen, smpA, smpB;
  logic             hitLow, hitA, hitB, hitEnd;

  ow_slot_timing #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_timing (
    .overdrive(overdrive), .opReset(opReset), .dataBit(dataBit),
    .rstLowStd(rstLowStd), .rstLowOd(rstLowOd),
    .presStd(presStd), .presOd(presOd),
    .w0LowStd(w0LowStd), .w0LowOd(w0LowOd), .recCode(recCode),
    .lowLen(lowLen), .endLen(endLen), .smpA(smpA), .smpB(smpB)
  );

  ow_slot_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .tickEn(tickEn),
    .opReset(opReset), .hitLow(hitLow), .hitA(hitA), .hitB(hitB),
    .hitEnd(hitEnd), .stb(stb), .busy(busy)
  );

  ow_slot_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .busHigh(busHigh),
    .lowLenIn(lowLen), .endLenIn(endLen), .smpAIn(smpA), .smpBIn(smpB),
    .hitLow(hitLow), .hitA(hitA), .hitB(hitB), .hitEnd(hitEnd),
    .pullLow(pullLow), .rdBit(rdBit), .presence(presence), .shortDet(shortDet)
  );

  AST_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pullLow |-> busy);  // R9
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(rdBit) && $stable(presence) && $stable(shortDet)));  // R9
  AST_END_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !pullLow);  // R1

endmodule

// File: tb/sim_owire_slot_gen.sv
`timescale 1ns/1ps
module sim_owire_slot_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tickEn = 1'b0, start = 1'b0, opReset = 1'b0, dataBit = 1'b0, overdrive = 1'b0;
  logic [3:0] rstLowStd = '0, rstLowOd = '0, presStd = '0, presOd = '0;
  logic [3:0] w0LowStd = '0, w0LowOd = '0, recCode = '0;
  logic busHigh = 1'b1;
  logic pullLow, busy, rdBit, presence, shortDet;

  int nChk = 0, nFail = 0;
  int lowTk, totTk;

  always #5 clk = ~clk;

  owire_slot_gen u0 (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .start(start), .opReset(opReset),
    .dataBit(dataBit), .overdrive(overdrive), .rstLowStd(rstLowStd), .rstLowOd(rstLowOd),
    .presStd(presStd), .presOd(presOd), .w0LowStd(w0LowStd), .w0LowOd(w0LowOd),
    .recCode(recCode), .busHigh(busHigh), .pullLow(pullLow), .busy(busy),
    .rdBit(rdBit), .presence(presence), .shortDet(shortDet)
  );

  // expected tick counts, from the requirements
  function automatic int w0T(bit od, int c);   return od ? 20 + c : 208 + 4 * c;   endfunction
  function automatic int recT(int c);          return 11 + 6 * c;                  endfunction
  function automatic int rstT(bit od, int c);  return od ? 176 + 8 * c : 1760 + 80 * c; endfunction
  function automatic int mspT(bit od, int c);  return od ? 22 + c : 232 + 4 * c;   endfunction
  function automatic int w1T(bit od);          return od ? 3 : 32;                 endfunction
  function automatic int msrT(bit od);         return od ? 7 : 48;                 endfunction
  function automatic int siT(bit od);          return od ? 3 : 32;                 endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic randCodes();
    rstLowStd = 4'($urandom_range(0, 15)); rstLowOd = 4'($urandom_range(0, 15));
    presStd   = 4'($urandom_range(0, 15)); presOd   = 4'($urandom_range(0, 15));
    w0LowStd  = 4'($urandom_range(0, 15)); w0LowOd  = 4'($urandom_range(0, 15));
    recCode   = 4'($urandom_range(0, 15));
  endtask

  // runs one operation; kA/kB are the sample ticks, aVal/bVal the levels shown there
  task automatic runOp(input bit rOp, input bit dB, input bit od, input int kA, input int kB,
                       input bit aVal, input bit bVal, input bit poke);
    @(negedge clk);
    opReset = rOp; dataBit = dB; overdrive = od; start = 1'b1; tickEn = 1'b0;
    @(negedge clk);
    start = 1'b0;
    lowTk = 0; totTk = 0;
    while (busy && totTk < 7000) begin
      if (poke && totTk == 10) begin
        start = 1'b1; opReset = !rOp; dataBit = !dB; overdrive = !od; randCodes();
        @(negedge clk);
        start = 1'b0;
      end
      repeat ($urandom_range(0, 2)) @(negedge clk);
      if (totTk + 1 == kA)      busHigh = aVal;
      else if (totTk + 1 == kB) busHigh = bVal;
      else if (totTk + 1 < kA)  busHigh = !aVal;
      else                      busHigh = rOp ? !bVal : !aVal;
      tickEn = 1'b1;
      if (pullLow) lowTk++;
      @(negedge clk);
      tickEn = 1'b0;
      totTk++;
    end
    busHigh = 1'b1;
  endtask

  task automatic doSlot(input bit dB, input bit od, input bit aVal, input bit poke);
    int expLow, expTot;
    string sp;
    sp = od ? "R7 od" : "R7 std";
    expLow = dB ? w1T(od) : w0T(od, int'(od ? w0LowOd : w0LowStd));
    expTot = w0T(od, int'(od ? w0LowOd : w0LowStd)) + recT(int'(recCode));
    runOp(1'b0, dB, od, msrT(od), 0, aVal, 1'b0, poke);
    if (dB) chk({"R2 low ticks ", sp}, lowTk, expLow);
    else    chk({"R1 low ticks ", sp}, lowTk, expLow);
    chk({"R1 slot ticks ", sp}, totTk, expTot);
    chk("R3 read sample", int'(rdBit), int'(aVal));
    chk("R9 presence cleared", int'(presence), 0);
    chk("R9 short cleared", int'(shortDet), 0);
    if (poke) chk("R8 busy done after ignored start", int'(busy), 0);
  endtask

  task automatic doReset(input bit od, input bit sVal, input bit pVal, input bit poke);
    int rl, kS, kP;
    string sp;
    sp = od ? "R7 od" : "R7 std";
    rl = rstT(od, int'(od ? rstLowOd : rstLowStd));
    kS = rl + siT(od);
    kP = rl + mspT(od, int'(od ? presOd : presStd));
    runOp(1'b1, 1'b0, od, kS, kP, sVal, pVal, poke);
    chk({"R4 low ticks ", sp}, lowTk, rl);
    chk({"R4 cycle ticks ", sp}, totTk, 2 * rl);
    chk("R5 short flag", int'(shortDet), int'(!sVal));
    chk("R6 presence flag", int'(presence), int'(!pVal));
    chk("R9 rdBit cleared", int'(rdBit), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk("R10 busy after reset", int'(busy), 0);
    chk("R10 pullLow after reset", int'(pullLow), 0);
    chk("R10 rdBit after reset", int'(rdBit) + int'(presence) + int'(shortDet), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: default-like write-zero and read slots at both speeds
    w0LowStd = 4'd12; w0LowOd = 4'd12; recCode = 4'd0;
    doSlot(1'b0, 1'b0, 1'b0, 1'b0);
    doSlot(1'b1, 1'b0, 1'b1, 1'b0);
    doSlot(1'b1, 1'b1, 1'b1, 1'b0);
    recCode = 4'd15; w0LowOd = 4'd15;
    doSlot(1'b0, 1'b1, 1'b1, 1'b1);

    // random bit slots
    for (int i = 0; i < 24; i++) begin
      randCodes();
      doSlot(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
             bit'($urandom_range(0, 1)), (i % 5) == 2);
    end

    // random overdrive resets, with a start poked in some
    for (int i = 0; i < 8; i++) begin
      randCodes();
      doReset(1'b1, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), (i % 3) == 1);
    end

    // standard-speed resets at extreme codes
    rstLowStd = 4'd0;  presStd = 4'd15;
    doReset(1'b0, 1'b1, 1'b0, 1'b0);
    rstLowStd = 4'd15; presStd = 4'd0;
    doReset(1'b0, 1'b0, 1'b1, 1'b1);

    // results hold over idle ticks
    doReset(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      busHigh = bit'(i % 2);
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
    busHigh = 1'b1;
    chk("R9 presence held", int'(presence), 1);
    chk("R9 short held", int'(shortDet), 1);
    chk("R9 busy idle", int'(busy) + int'(pullLow), 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule